// File: doc/BRIEF.md
# Flash Command and Embedded-Operation Controller

This block is the device side of the write interface of a byte-wide flash memory. An external master drives address, data, an active-low write strobe and an active-low chip enable as an asynchronous-style bus. The block samples these on its system clock and decodes command cycles. A three-cycle unlock sequence followed by one address/data cycle programs a byte. A longer sequence, ending in one or more sector-address cycles, erases whole sectors. The memory itself is a behavioural byte array, split into a parameterised number of equal sectors.

Program and erase run by themselves once the command is accepted. While an operation is busy, the master learns its progress by reading bit 7 of the data bus at an address that the operation touches. Erase first clears every byte of the selected sectors to zero, then sets them to all ones. Erase does not start until a quiet window has passed, so more sectors can be added while the window is open. A reset command returns the block to read mode at any time and aborts a running operation. Program time, the erase window and the per-sector erase time are counted in clock cycles. The address width must be at least 11 bits so that the unlock addresses fit.

Top module: `flash_ctrl`

## Requirements
- R1: After the synchronous reset the block is in read mode. A read returns the stored byte two clock edges after the address is applied. The array powers up with every byte at 0xFF.
- R2: The writes 0x555/0xAA, 0x2AA/0x55, 0x555/0xA0, then one write of target address and data, store that data at the target address once the program time has elapsed. Afterwards the block is back in read mode.
- R3: A write cycle is active while both strobes are low. The target address is the one present in the first sampled cycle of the active phase. The data is the one present when the cycle ends.
- R4: While a program is busy, a read at the target address returns 0x80 if bit 7 of the data is 0, and 0x00 if it is 1. After completion the read returns the data, so D7 equals the written bit 7.
- R5: While a program is busy, every write other than a 0xF0 data write has no effect. A full program sequence to another address leaves that address unchanged.
- R6: A write that does not match the next expected cycle of a sequence returns the decoder to read mode. Later writes must start a fresh unlock.
- R7: The sequence 0x555/0xAA, 0x2AA/0x55, 0x555/0x80, 0x555/0xAA, 0x2AA/0x55 followed by a write of data 0x30 erases the sector named by the upper address bits. Every byte of that sector becomes 0xFF. Sectors not selected keep their contents.
- R8: A further write of data 0x30 that ends before the erase window has expired adds its sector to the erase set and restarts the window.
- R9: Erase first writes 0x00 to every byte of the selected sectors, in ascending address order, before setting any of them to 0xFF.
- R10: While the erase passes run, a read inside a selected sector returns 0x00. After completion it returns 0xFF, so D7 reads 1.
- R11: A write with data 0xF0 during a busy operation aborts it and returns the block to read mode. The location being worked on becomes 0xA5: the program target, or the current erase location if that location lies in a selected sector. Unselected sectors stay untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Byte address for reads and command cycles |
| din | input | 8 | Write data / command code |
| we_n | input | 1 | Active-low write strobe |
| ce_n | input | 1 | Active-low chip enable |
| dout | output | 8 | Read data or operation status |

## Verification
The collision of interest is a reset command that ends in the same cycle in which a program reaches its final count. Both events want to write the target byte and to leave busy mode. The bench sweeps the delay between the program cycle and a 0xF0 write across the end of the program time. Well before the end, it expects the abort value 0xA5. Well after the end, it expects the written data. In the narrow band between, it accepts exactly one of the two values, and in every case the block must be back in read mode with no other byte disturbed.

// File: rtl/flash_pkg.sv
package flash_pkg;
  localparam int BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;

  localparam byte_t CMD_UNLK1 = 8'hAA;
  localparam byte_t CMD_UNLK2 = 8'h55;
  localparam byte_t CMD_PROG  = 8'hA0;
  localparam byte_t CMD_ERSET = 8'h80;
  localparam byte_t CMD_SECT  = 8'h30;
  localparam byte_t CMD_RST   = 8'hF0;

  localparam int CMD_AW = 11;
  localparam logic [CMD_AW-1:0] ADR_U1 = 11'h555;
  localparam logic [CMD_AW-1:0] ADR_U2 = 11'h2AA;

  typedef enum logic [3:0] {
    ST_READ, ST_C1, ST_C2, ST_PSET, ST_E1, ST_E2, ST_E3,
    ST_EWIN, ST_PROG, ST_PRE, ST_ERS
  } fst_t;
endpackage

// File: rtl/flash_bus_sync.sv
module flash_bus_sync
  import flash_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we_n,
  input  logic              ce_n,
  input  logic [ADDR_W-1:0] addr,
  input  byte_t             din,
  output logic [ADDR_W-1:0] addr_q,
  output logic              cmd_rise,
  output logic [ADDR_W-1:0] cmd_addr,
  output byte_t             cmd_data
);
  logic  we_q, ce_q, strb_d;
  byte_t din_q;
  logic  strb;

  assign strb     = ~we_q & ~ce_q;
  assign cmd_rise = ~strb & strb_d;
  assign cmd_data = din_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      we_q     <= 1'b1;
      ce_q     <= 1'b1;
      strb_d   <= 1'b0;
      addr_q   <= '0;
      din_q    <= '0;
      cmd_addr <= '0;
    end else begin
      we_q   <= we_n;
      ce_q   <= ce_n;
      addr_q <= addr;
      din_q  <= din;
      strb_d <= strb;
      if (strb && !strb_d) cmd_addr <= addr_q;
    end
  end
endmodule

// File: rtl/flash_array.sv
module flash_array
  import flash_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  byte_t             wdata,
  input  logic [ADDR_W-1:0] raddr,
  output byte_t             q
);
  localparam int DEPTH = 1 << ADDR_W;
  byte_t mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '1;
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    q <= mem[raddr];
  end
endmodule

// File: rtl/flash_ctrl.sv
module flash_ctrl
  import flash_pkg::*;
#(
  parameter int    ADDR_W    = 11,
  parameter int    SECT_W    = 2,
  parameter int    PROG_CYC  = 60,
  parameter int    ERASE_WIN = 50,
  parameter int    ERASE_CYC = 100,
  parameter byte_t GARBAGE   = 8'hA5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  input  logic              we_n,
  input  logic              ce_n,
  output logic [7:0]        dout
);
  localparam int NSECT = 1 << SECT_W;
  localparam int OFS_W = ADDR_W - SECT_W;
  localparam int MAXC  = (PROG_CYC > ERASE_WIN) ?
                         ((PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC) :
                         ((ERASE_WIN > ERASE_CYC) ? ERASE_WIN : ERASE_CYC);
  localparam int TMR_W = $clog2(MAXC + 1);

  logic [ADDR_W-1:0] addr_q, cmd_addr, p_addr, ptr, arr_waddr;
  byte_t             cmd_data, p_data, q, st_val, arr_wdata;
  logic              cmd_rise, st_hit, arr_we;
  fst_t              st;
  logic [NSECT-1:0]  sel_mask;
  logic [TMR_W-1:0]  tmr;

  flash_bus_sync #(.ADDR_W(ADDR_W)) u_sync (
    .clk(clk), .rst(rst), .we_n(we_n), .ce_n(ce_n), .addr(addr), .din(din),
    .addr_q(addr_q), .cmd_rise(cmd_rise), .cmd_addr(cmd_addr), .cmd_data(cmd_data)
  );

  flash_array #(.ADDR_W(ADDR_W)) u_arr (
    .clk(clk), .we(arr_we), .waddr(arr_waddr), .wdata(arr_wdata),
    .raddr(addr_q), .q(q)
  );

  logic is_u1, is_u2, is_prog, is_er, is_sect, abort;
  logic ptr_sel, ptr_first, ptr_last, ers_wait, prog_done, win_done;
  logic [NSECT-1:0] cmd_sect_bit;

  assign is_u1   = cmd_rise && cmd_addr[CMD_AW-1:0] == ADR_U1 && cmd_data == CMD_UNLK1;
  assign is_u2   = cmd_rise && cmd_addr[CMD_AW-1:0] == ADR_U2 && cmd_data == CMD_UNLK2;
  assign is_prog = cmd_rise && cmd_addr[CMD_AW-1:0] == ADR_U1 && cmd_data == CMD_PROG;
  assign is_er   = cmd_rise && cmd_addr[CMD_AW-1:0] == ADR_U1 && cmd_data == CMD_ERSET;
  assign is_sect = cmd_rise && cmd_data == CMD_SECT;
  assign abort   = cmd_rise && cmd_data == CMD_RST;

  assign cmd_sect_bit = NSECT'(1) << cmd_addr[ADDR_W-1 -: SECT_W];
  assign ptr_sel   = sel_mask[ptr[ADDR_W-1 -: SECT_W]];
  assign ptr_first = ptr[OFS_W-1:0] == '0;
  assign ptr_last  = &ptr;
  assign ers_wait  = ptr_sel && ptr_first && tmr != TMR_W'(ERASE_CYC - 1);
  assign prog_done = tmr == TMR_W'(PROG_CYC - 1);
  assign win_done  = tmr == TMR_W'(ERASE_WIN - 1);

  // Array write port: the only writer of the memory.
  always_comb begin
    arr_we    = 1'b0;
    arr_waddr = ptr;
    arr_wdata = '0;
    case (st)
      ST_PROG: begin
        arr_waddr = p_addr;
        if (abort) begin
          arr_we = 1'b1; arr_wdata = GARBAGE;
        end else if (prog_done) begin
          arr_we = 1'b1; arr_wdata = p_data;
        end
      end
      ST_PRE: begin
        arr_we    = ptr_sel;
        arr_wdata = abort ? GARBAGE : '0;
      end
      ST_ERS: begin
        if (abort) begin
          arr_we = ptr_sel; arr_wdata = GARBAGE;
        end else begin
          arr_we = ptr_sel && !ers_wait; arr_wdata = '1;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_READ;
      sel_mask <= '0;
      tmr      <= '0;
      ptr      <= '0;
      p_addr   <= '0;
      p_data   <= '0;
    end else begin
      case (st)
        ST_READ: if (is_u1) st <= ST_C1;
        ST_C1:   if (cmd_rise) st <= is_u2 ? ST_C2 : ST_READ;
        ST_C2:   if (cmd_rise) st <= is_prog ? ST_PSET : (is_er ? ST_E1 : ST_READ);
        ST_PSET: if (cmd_rise) begin
          if (abort) st <= ST_READ;
          else begin
            p_addr <= cmd_addr;
            p_data <= cmd_data;
            tmr    <= '0;
            st     <= ST_PROG;
          end
        end
        ST_E1: if (cmd_rise) st <= is_u1 ? ST_E2 : ST_READ;
        ST_E2: if (cmd_rise) st <= is_u2 ? ST_E3 : ST_READ;
        ST_E3: if (cmd_rise) begin
          if (is_sect) begin
            sel_mask <= sel_mask | cmd_sect_bit;
            tmr      <= '0;
            st       <= ST_EWIN;
          end else st <= ST_READ;
        end
        ST_EWIN: begin
          if (cmd_rise) begin
            if (is_sect) begin
              sel_mask <= sel_mask | cmd_sect_bit;
              tmr      <= '0;
            end else begin
              sel_mask <= '0;
              st       <= ST_READ;
            end
          end else if (win_done) begin
            ptr <= '0;
            st  <= ST_PRE;
          end else tmr <= tmr + 1'b1;
        end
        ST_PROG: begin
          if (abort || prog_done) st <= ST_READ;
          else tmr <= tmr + 1'b1;
        end
        ST_PRE: begin
          if (abort) begin
            sel_mask <= '0;
            st       <= ST_READ;
          end else begin
            ptr <= ptr + 1'b1;
            if (ptr_last) begin
              tmr <= '0;
              st  <= ST_ERS;
            end
          end
        end
        ST_ERS: begin
          if (abort) begin
            sel_mask <= '0;
            st       <= ST_READ;
          end else if (ers_wait) tmr <= tmr + 1'b1;
          else begin
            ptr <= ptr + 1'b1;
            tmr <= '0;
            if (ptr_last) begin
              sel_mask <= '0;
              st       <= ST_READ;
            end
          end
        end
        default: st <= ST_READ;
      endcase
    end
  end

  // Status path, aligned with the registered array read.
  always_ff @(posedge clk) begin
    if (rst) begin
      st_hit <= 1'b0;
      st_val <= '0;
    end else begin
      st_hit <= (st == ST_PROG && addr_q == p_addr) ||
                ((st == ST_PRE || st == ST_ERS) && sel_mask[addr_q[ADDR_W-1 -: SECT_W]]);
      st_val <= (st == ST_PROG) ? {~p_data[7], 7'b0} : '0;
    end
  end

  assign dout = st_hit ? st_val : q;
endmodule

// File: rtl/flash_ctrl_chk.sv
module flash_ctrl_chk
  import flash_pkg::*;
#(
  parameter int ADDR_W   = 11,
  parameter int NSECT    = 4,
  parameter int TMR_W    = 7,
  parameter int PROG_CYC = 60
) (
  input logic              clk,
  input logic              rst,
  input fst_t              st,
  input logic              cmd_rise,
  input byte_t             cmd_data,
  input logic [TMR_W-1:0]  tmr,
  input logic [ADDR_W-1:0] p_addr,
  input logic [NSECT-1:0]  sel_mask
);
  logic busy;
  assign busy = st == ST_PROG || st == ST_PRE || st == ST_ERS;

  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> st == ST_READ);

  // R11
  abort_read_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && cmd_rise && cmd_data == CMD_RST) |=> st == ST_READ);

  // R5
  prog_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_PROG && cmd_rise && cmd_data != CMD_RST && tmr != TMR_W'(PROG_CYC - 1))
      |=> st == ST_PROG);

  // R3
  paddr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_PROG && $past(st) == ST_PROG) |-> $stable(p_addr));

  // R2
  prog_finish_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_PROG && !(cmd_rise && cmd_data == CMD_RST) && tmr == TMR_W'(PROG_CYC - 1))
      |=> st == ST_READ);

  // R7
  mask_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ((st == ST_PRE || st == ST_ERS) && ($past(st) == ST_PRE || $past(st) == ST_ERS))
      |-> $stable(sel_mask));
endmodule

bind flash_ctrl flash_ctrl_chk #(
  .ADDR_W(ADDR_W), .NSECT(NSECT), .TMR_W(TMR_W), .PROG_CYC(PROG_CYC)
) u_chk (
  .clk(clk), .rst(rst), .st(st), .cmd_rise(cmd_rise), .cmd_data(cmd_data),
  .tmr(tmr), .p_addr(p_addr), .sel_mask(sel_mask)
);

// File: tb/flash_ctrl_test.sv
`timescale 1ns/1ps
module flash_ctrl_test;
  localparam int AW = 11;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [7:0]    din = '0;
  logic          we_n = 1'b1;
  logic          ce_n = 1'b1;
  logic [7:0]    dout;

  int checks = 0;
  int failures = 0;
  logic [7:0] model [DEPTH];

  always #2.5 clk = ~clk;

  flash_ctrl #(.ADDR_W(AW)) uut (
    .clk(clk), .rst(rst), .addr(addr), .din(din), .we_n(we_n), .ce_n(ce_n), .dout(dout)
  );

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; din = d; we_n = 1'b0; ce_n = 1'b0;
    @(negedge clk); @(negedge clk);
    we_n = 1'b1; ce_n = 1'b1;
    @(negedge clk); @(negedge clk);
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    repeat (3) @(negedge clk);
    d = dout;
  endtask

  task automatic unlock();
    wr(11'h555, 8'hAA);
    wr(11'h2AA, 8'h55);
  endtask

  task automatic prog_cmd(input logic [AW-1:0] a, input logic [7:0] d);
    unlock();
    wr(11'h555, 8'hA0);
    wr(a, d);
  endtask

  task automatic poll(input logic [AW-1:0] a, input logic b7, input string req);
    logic [7:0] v;
    int n = 0;
    rd(a, v);
    while (v[7] !== b7 && n < 3000) begin
      rd(a, v);
      n++;
    end
    check(req, {7'b0, v[7]}, {7'b0, b7});
  endtask

  function automatic logic [7:0] busy_prog_status(input logic [7:0] d);
    return {~d[7], 7'b0};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL R1 watchdog actual=hung expected=finished");
    summary();
  end

  initial begin
    logic [7:0] v;
    logic [AW-1:0] a;
    logic [7:0] d;
    void'($urandom(32'd20240611));
    for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;

    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1: reset state, erased array
    rd(11'h000, v); check("R1 addr000", v, 8'hFF);
    rd(11'h7FF, v); check("R1 addr7FF", v, 8'hFF);

    // R2 / R4: directed program with status while busy
    prog_cmd(11'h123, 8'h3C);
    rd(11'h123, v); check("R4 busy status", v, busy_prog_status(8'h3C));
    poll(11'h123, 1'b0, "R4 poll D7");
    rd(11'h123, v); check("R2 programmed", v, 8'h3C);
    model[11'h123] = 8'h3C;
    prog_cmd(11'h124, 8'hC1);
    rd(11'h124, v); check("R4 busy status b7=1", v, busy_prog_status(8'hC1));
    poll(11'h124, 1'b1, "R4 poll D7 b7=1");
    model[11'h124] = 8'hC1;
    rd(11'h124, v); check("R2 programmed b7=1", v, 8'hC1);

    // R3: address from strobe start, data from strobe end
    unlock();
    wr(11'h555, 8'hA0);
    @(negedge clk);
    addr = 11'h150; din = 8'h11; we_n = 1'b0; ce_n = 1'b0;
    @(negedge clk);
    addr = 11'h151; din = 8'h66;
    @(negedge clk);
    we_n = 1'b1; ce_n = 1'b1;
    @(negedge clk); @(negedge clk);
    poll(11'h150, 1'b0, "R3 poll");
    rd(11'h150, v); check("R3 latched addr/data", v, 8'h66);
    rd(11'h151, v); check("R3 other addr untouched", v, 8'hFF);
    model[11'h150] = 8'h66;

    // R5: commands during program ignored
    prog_cmd(11'h160, 8'h0F);
    prog_cmd(11'h161, 8'h00);
    poll(11'h160, 1'b0, "R5 poll");
    rd(11'h160, v); check("R5 first program", v, 8'h0F);
    rd(11'h161, v); check("R5 ignored program", v, 8'hFF);
    model[11'h160] = 8'h0F;

    // R6: broken sequence returns to read mode
    wr(11'h555, 8'hAA);
    wr(11'h2AA, 8'h54);
    wr(11'h555, 8'hA0);
    wr(11'h200, 8'h11);
    repeat (80) @(negedge clk);
    rd(11'h200, v); check("R6 no write after bad cycle", v, 8'hFF);
    prog_cmd(11'h201, 8'h22);
    poll(11'h201, 1'b0, "R6 fresh unlock poll");
    rd(11'h201, v); check("R6 fresh unlock works", v, 8'h22);
    model[11'h201] = 8'h22;

    // R11: abort during program
    prog_cmd(11'h300, 8'h77);
    wr(11'h000, 8'hF0);
    rd(11'h300, v); check("R11 abort garbage", v, 8'hA5);
    rd(11'h301, v); check("R11 neighbour", v, 8'hFF);
    model[11'h300] = 8'hA5;

    // Collision sweep: reset command around program completion
    for (int k = 0; k <= 80; k += 8) begin
      a = AW'(11'h400 + k);
      d = 8'h40 + 8'(k);
      prog_cmd(a, d);
      repeat (k) @(negedge clk);
      wr(11'h000, 8'hF0);
      repeat (70) @(negedge clk);
      rd(a, v);
      if (k <= 45) check("R11 sweep early", v, 8'hA5);
      else if (k >= 65) check("R2 sweep late", v, d);
      else check("R11 sweep edge", (v == 8'hA5 || v == d) ? 8'h01 : 8'h00, 8'h01);
      model[a] = v;
    end

    // R2: random programs in sector 3
    for (int i = 0; i < 40; i++) begin
      a = AW'(11'h600 + ($urandom % 512));
      d = 8'($urandom);
      prog_cmd(a, d);
      poll(a, d[7], "R2 random poll");
      model[a] = d;
    end
    for (int i = 0; i < 20; i++) begin
      a = AW'(11'h600 + ($urandom % 512));
      rd(a, v); check("R2 random readback", v, model[a]);
    end

    // R7 / R8 / R10: erase sectors 1 and 2
    prog_cmd(11'h010, 8'h5A); poll(11'h010, 1'b0, "R7 setup"); model[11'h010] = 8'h5A;
    prog_cmd(11'h210, 8'hC3); poll(11'h210, 1'b1, "R7 setup"); model[11'h210] = 8'hC3;
    unlock();
    wr(11'h555, 8'h80);
    unlock();
    wr(11'h200, 8'h30);
    wr(11'h400, 8'h30);
    repeat (100) @(negedge clk);
    rd(11'h210, v); check("R10 erase busy status", v, 8'h00);
    rd(11'h010, v); check("R7 unselected during erase", v, 8'h5A);
    poll(11'h440, 1'b1, "R10 erase done D7");
    rd(11'h210, v); check("R7 erased sector1", v, 8'hFF);
    rd(11'h408, v); check("R8 added sector2 erased", v, 8'hFF);
    rd(11'h450, v); check("R8 added sector2 erased", v, 8'hFF);
    for (int i = 11'h200; i < 11'h600; i++) model[i] = 8'hFF;
    rd(11'h010, v); check("R7 sector0 untouched", v, 8'h5A);
    for (int i = 0; i < 8; i++) begin
      a = AW'(11'h600 + ($urandom % 512));
      rd(a, v); check("R7 sector3 untouched", v, model[a]);
    end

    // R9 / R11: abort erase of sector 0 during the zero pass
    unlock();
    wr(11'h555, 8'h80);
    unlock();
    wr(11'h000, 8'h30);
    repeat (350) @(negedge clk);
    wr(11'h000, 8'hF0);
    rd(11'h000, v); check("R9 pre-programmed 000", v, 8'h00);
    rd(11'h010, v); check("R9 pre-programmed 010", v, 8'h00);
    rd(11'h210, v); check("R11 unselected after abort", v, 8'hFF);
    rd(11'h150 + 11'h500, v); check("R11 sector3 after abort", v, model[11'h650]);
    prog_cmd(11'h7F0, 8'h99);
    poll(11'h7F0, 1'b1, "R11 program after abort");
    rd(11'h7F0, v); check("R11 read mode after abort", v, 8'h99);

    summary();
  end
endmodule